// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable model of a single-clock SRAM with an 18-bit word split into two 9-bit lanes. Lane 0 is `data_io[8:0]` and lane 1 is `data_io[17:9]`. Address, write data, the three selects, both start strobes, the advance input and all write controls are sampled on the rising edge of `clk_i`. The array depth is a parameter.

A burst opens on either start strobe while the part is selected. The sampled address becomes the burst base. Later cycles without a strobe continue the burst. With `next_n_i` low, a 2-bit counter steps and builds the low two address bits from the base, in one of two orders. With `next_n_i` high, the same address is accessed again.

Reads are pipelined: the word shows on the shared bus one edge after its address was sampled. Because of the output register, the bus keeps driving for one more cycle after a deselect. The output enable gates the bus without waiting for the clock. Writes commit at the same edge that samples them. A sleep input freezes all access.

Top module: `sync_burst_sram`

## Requirements
- R1: An access takes place only when `sel_n_i`=0, `sel_hi_i`=1 and `sel2_n_i`=0. A start strobe that arrives while any of these three does not hold ends the burst and performs no read or write.
- R2: A low `strb_cpu_n_i` or `strb_ctl_n_i` with the part selected starts a burst. The first access goes to `addr_i` as sampled at that edge.
- R3: In a burst cycle without a strobe, `next_n_i`=0 steps the 2-bit count and `next_n_i`=1 repeats the current address. The count wraps from 3 back to 0.
- R4: With `order_ilv_i`=1, the low two address bits are the base bits XOR the count.
- R5: With `order_ilv_i`=0, the low two address bits are the base bits plus the count, modulo 4.
- R6: Bit 0 of `lane_wr_n_i` (active low) writes lane 0 (`data_io[8:0]`). Bit 1 writes lane 1 (`data_io[17:9]`). A disabled lane keeps its old contents.
- R7: `wr_all_n_i`=0 writes both lanes, whatever `lane_wr_n_i` holds.
- R8: A cycle started by `strb_cpu_n_i` is a read even when write controls are active. Only a cycle started by `strb_ctl_n_i`, or a burst continuation, with a write control active, writes.
- R9: A read word is driven on `data_io` after the clock edge that follows the edge that sampled its address.
- R10: After a deselect, the bus still drives the last read word for one cycle. From the next edge on, it floats.
- R11: `out_en_n_i`=1 floats `data_io` at once, without waiting for a clock edge.
- R12: While `sleep_i`=1, no read or write takes place, `data_io` floats, and the array keeps its contents.
- R13: The bus is never driven in a cycle whose inputs request a write, nor in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low (control state only) |
| addr_i | input | AW | Word address |
| data_io | inout | 18 | Shared write-data / read-data bus |
| sel_n_i | input | 1 | Select, active low |
| sel_hi_i | input | 1 | Select, active high |
| sel2_n_i | input | 1 | Second select, active low |
| strb_cpu_n_i | input | 1 | Start strobe, always a read, active low |
| strb_ctl_n_i | input | 1 | Start strobe, read or write, active low |
| next_n_i | input | 1 | Burst advance, active low |
| lane_wr_n_i | input | 2 | Per-lane write enables, active low |
| wr_all_n_i | input | 1 | Write-all-lanes, active low |
| order_ilv_i | input | 1 | 1 selects XOR order, 0 selects wrapping increment |
| out_en_n_i | input | 1 | Output enable, active low, acts without the clock |
| sleep_i | input | 1 | Blocks all access and floats the bus |

## Verification
The bench runs the same 2-bit count from a base of 1 in both orders. For that base the XOR and additive sequences differ, so swapping the two orders, or letting the count saturate instead of wrap, returns the wrong word. The bench also probes the pipeline at its edges:
- A missing output register shifts every read by one cycle.
- A single-cycle deselect floats the bus one cycle too early.
- Driving after a write shows read data where the bus should float.

For the write paths, a write strobed by the always-read strobe corrupts a word that is later read back. A disabled lane that is still written changes its half of the readback. A sleep or chip-select decode that leaks lets a blocked write overwrite a word, or lets a read reach the bus.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned CNT_W = 2;

  // low address bits for burst step cnt from base
  function automatic logic [CNT_W-1:0] burst_lsb(input logic [CNT_W-1:0] base,
                                                 input logic [CNT_W-1:0] cnt,
                                                 input logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             sel_n_i,
  input  logic             sel_hi_i,
  input  logic             sel2_n_i,
  input  logic             strb_cpu_n_i,
  input  logic             strb_ctl_n_i,
  input  logic             next_n_i,
  input  logic [LANES-1:0] lane_wr_n_i,
  input  logic             wr_all_n_i,
  input  logic             order_ilv_i,
  input  logic             sleep_i,
  output logic [AW-1:0]    acc_addr_o,
  output logic             rd_o,
  output logic [LANES-1:0] lane_we_o,
  output logic             wr_o
);
  localparam int unsigned HW = AW - CNT_W;

  logic            act_q;
  logic [HW-1:0]   hi_q;
  logic [CNT_W-1:0] base_q, cnt_q, cnt_nxt;
  logic            sel, strobe, start, desel, cont, access, wr_ctl, wr_cyc;

  assign sel    = !sel_n_i && sel_hi_i && !sel2_n_i;
  assign strobe = !strb_cpu_n_i || !strb_ctl_n_i;
  assign start  = !sleep_i && strobe && sel;
  assign desel  = !sleep_i && strobe && !sel;
  assign cont   = !sleep_i && !strobe && act_q;
  assign access = start || cont;

  assign wr_ctl = !wr_all_n_i || !(&lane_wr_n_i);
  // cpu strobe forces a read cycle
  assign wr_cyc = access && wr_ctl && !(start && !strb_cpu_n_i);

  assign cnt_nxt = next_n_i ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    if (start) acc_addr_o = addr_i;
    else       acc_addr_o = {hi_q, burst_lsb(base_q, cnt_nxt, order_ilv_i)};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we_o[g] = wr_cyc && (!wr_all_n_i || !lane_wr_n_i[g]);
  end

  assign rd_o = access && !wr_cyc;
  assign wr_o = wr_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      hi_q   <= addr_i[AW-1:CNT_W];
      base_q <= addr_i[CNT_W-1:0];
      cnt_q  <= '0;
    end else if (desel) begin
      act_q  <= 1'b0;
    end else if (cont) begin
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sbs_out_pipe.sv
module sbs_out_pipe #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          issue_o,
  output logic [DW-1:0] dout_o,
  output logic          valid_o
);
  logic          issue_q, valid_q;
  logic [AW-1:0] raddr_q;
  logic [DW-1:0] dout_q;

  // stage 1: registered read address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_q <= 1'b0;
      raddr_q <= '0;
    end else begin
      issue_q <= rd_i;
      if (rd_i) raddr_q <= addr_i;
    end
  end

  // stage 2: output register; valid lags issue, giving the two-cycle deselect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      valid_q <= issue_q;
      if (issue_q) dout_q <= rdata_i;
    end
  end

  assign raddr_o = raddr_q;
  assign issue_o = issue_q;
  assign dout_o  = dout_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned LANES = 2,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  inout  wire  [DW-1:0]    data_io,
  input  logic             sel_n_i,
  input  logic             sel_hi_i,
  input  logic             sel2_n_i,
  input  logic             strb_cpu_n_i,
  input  logic             strb_ctl_n_i,
  input  logic             next_n_i,
  input  logic [LANES-1:0] lane_wr_n_i,
  input  logic             wr_all_n_i,
  input  logic             order_ilv_i,
  input  logic             out_en_n_i,
  input  logic             sleep_i
);
  logic [AW-1:0]    acc_addr, rd_addr;
  logic [LANES-1:0] lane_we;
  logic             rd_req, wr_req, rd_issue, out_valid, drv_en;
  logic [DW-1:0]    rdata, dout, wdata;

  assign wdata = data_io;

  sbs_burst_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .sel_n_i      (sel_n_i),
    .sel_hi_i     (sel_hi_i),
    .sel2_n_i     (sel2_n_i),
    .strb_cpu_n_i (strb_cpu_n_i),
    .strb_ctl_n_i (strb_ctl_n_i),
    .next_n_i     (next_n_i),
    .lane_wr_n_i  (lane_wr_n_i),
    .wr_all_n_i   (wr_all_n_i),
    .order_ilv_i  (order_ilv_i),
    .sleep_i      (sleep_i),
    .acc_addr_o   (acc_addr),
    .rd_o         (rd_req),
    .lane_we_o    (lane_we),
    .wr_o         (wr_req)
  );

  sbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (lane_we),
    .waddr_i (acc_addr),
    .wdata_i (wdata),
    .raddr_i (rd_addr),
    .rdata_o (rdata)
  );

  sbs_out_pipe #(.AW(AW), .DW(DW)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_req),
    .addr_i  (acc_addr),
    .rdata_i (rdata),
    .raddr_o (rd_addr),
    .issue_o (rd_issue),
    .dout_o  (dout),
    .valid_o (out_valid)
  );

  // write cycles keep drivers off so the write data owns the bus
  assign drv_en  = out_valid && !out_en_n_i && !sleep_i && !wr_req;
  assign data_io = drv_en ? dout : {DW{1'bz}};
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_n_i,
  input logic             sel_hi_i,
  input logic             sel2_n_i,
  input logic             strb_cpu_n_i,
  input logic             strb_ctl_n_i,
  input logic             next_n_i,
  input logic [LANES-1:0] lane_wr_n_i,
  input logic             wr_all_n_i,
  input logic             sleep_i,
  input logic             rd_issue_i,
  input logic [AW-1:0]    raddr_i,
  input logic [LANES-1:0] lane_we_i,
  input logic             drv_en_i
);
  logic sel_in, strobe_in, no_wr_in;
  assign sel_in    = !sel_n_i && sel_hi_i && !sel2_n_i;
  assign strobe_in = !strb_cpu_n_i || !strb_ctl_n_i;
  assign no_wr_in  = wr_all_n_i && (&lane_wr_n_i);

  a_r1_desel_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_in && !sel_in) |=> !rd_issue_i);

  a_r1_desel_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_in && !sel_in) |-> (lane_we_i == '0));

  a_r3_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_in && next_n_i && no_wr_in && !sleep_i && rd_issue_i)
      |=> (rd_issue_i && raddr_i == $past(raddr_i)));

  a_r8_cpu_strobe_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_n_i && sel_in) |-> (lane_we_i == '0));

  a_r12_sleep_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (lane_we_i == '0));

  a_r12_sleep_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !rd_issue_i);

  a_r9_drive_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_i |-> $past(rd_issue_i));
endmodule

bind sync_burst_sram sbs_checker #(.AW(AW), .LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_n_i      (sel_n_i),
  .sel_hi_i     (sel_hi_i),
  .sel2_n_i     (sel2_n_i),
  .strb_cpu_n_i (strb_cpu_n_i),
  .strb_ctl_n_i (strb_ctl_n_i),
  .next_n_i     (next_n_i),
  .lane_wr_n_i  (lane_wr_n_i),
  .wr_all_n_i   (wr_all_n_i),
  .sleep_i      (sleep_i),
  .rd_issue_i   (rd_issue),
  .raddr_i      (rd_addr),
  .lane_we_i    (lane_we),
  .drv_en_i     (drv_en)
);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int DW = 18;
  localparam logic [DW-1:0] ZV = '1; // floating bus reads all ones via pull-ups
  localparam logic [DW-1:0] W0 = 18'h00101, W1 = 18'h01212, W2 = 18'h02323, W3 = 18'h03434;
  localparam logic [1:0] CK_NONE = 2'd0, CK_Z = 2'd1, CK_D = 2'd2;

  typedef struct packed {
    logic        cpu_n, ctl_n, nxt_n, sel_n, wall_n;
    logic [1:0]  lwr_n;
    logic        ilv;
    logic [7:0]  addr;
    logic [17:0] wd;
    logic [1:0]  ck;
    logic [17:0] exp;
    logic [3:0]  req;
  } vec_t;

  // cpu ctl nxt seln wall lwr ilv addr wd ck exp req
  localparam vec_t VECS [27] = '{
    '{1,0,1,0,0,2'b11,0,8'h10,W0,CK_NONE,'0,4'd7},       // R7 write burst start
    '{1,1,0,0,0,2'b11,0,8'h00,W1,CK_NONE,'0,4'd3},
    '{1,1,0,0,0,2'b11,0,8'h00,W2,CK_NONE,'0,4'd3},
    '{1,1,0,0,0,2'b11,0,8'h00,W3,CK_NONE,'0,4'd3},
    '{0,1,1,0,1,2'b11,0,8'h11,'0,CK_Z,ZV,4'd13},         // R13 no drive after write
    '{1,1,0,0,1,2'b11,0,8'h00,'0,CK_D,W1,4'd9},          // R9 first word
    '{1,1,0,0,1,2'b11,0,8'h00,'0,CK_D,W2,4'd5},          // R5
    '{1,1,0,0,1,2'b11,0,8'h00,'0,CK_D,W3,4'd5},
    '{1,1,0,0,1,2'b11,0,8'h00,'0,CK_D,W0,4'd5},
    '{1,1,1,0,1,2'b11,0,8'h00,'0,CK_D,W1,4'd3},          // R3 wrap
    '{1,1,1,0,1,2'b11,0,8'h00,'0,CK_D,W1,4'd3},          // R3 hold
    '{1,0,1,0,1,2'b11,1,8'h11,'0,CK_D,W1,4'd3},
    '{1,1,0,0,1,2'b11,1,8'h00,'0,CK_D,W1,4'd2},          // R2
    '{1,1,0,0,1,2'b11,1,8'h00,'0,CK_D,W0,4'd4},          // R4
    '{1,1,0,0,1,2'b11,1,8'h00,'0,CK_D,W3,4'd4},
    '{1,0,1,1,1,2'b11,0,8'h00,'0,CK_D,W2,4'd10},         // R10 still drives
    '{1,1,1,0,1,2'b11,0,8'h00,'0,CK_Z,ZV,4'd10},         // R10 floats
    '{1,0,1,0,0,2'b11,0,8'h20,18'h15555,CK_NONE,'0,4'd6},
    '{1,1,1,0,1,2'b10,0,8'h00,18'h2AAAA,CK_NONE,'0,4'd6},
    '{1,1,1,0,1,2'b01,0,8'h00,18'h3FFFF,CK_NONE,'0,4'd6},
    '{0,1,1,0,0,2'b11,0,8'h20,'0,CK_Z,ZV,4'd8},          // R8
    '{1,0,1,1,1,2'b11,0,8'h00,'0,CK_D,18'h3FEAA,4'd6},   // R6 lanes, R8 no write
    '{1,1,1,0,1,2'b11,0,8'h00,'0,CK_Z,ZV,4'd10},
    '{1,0,1,0,0,2'b00,0,8'h21,18'h12345,CK_NONE,'0,4'd7},
    '{1,0,1,0,1,2'b11,0,8'h21,'0,CK_Z,ZV,4'd13},
    '{1,0,1,1,1,2'b11,0,8'h00,'0,CK_D,18'h12345,4'd7},   // R7 wall vs lanes
    '{1,1,1,0,1,2'b11,0,8'h00,'0,CK_Z,ZV,4'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr;
  logic sel_n, sel_hi, sel2_n, cpu_n, ctl_n, nxt_n, wall_n, ilv, oe_n, slp;
  logic [1:0] lwr_n;
  logic tb_drv;
  logic [DW-1:0] tb_wd;
  wire  [DW-1:0] dq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup pu (dq[i]);
  end
  assign dq = tb_drv ? tb_wd : {DW{1'bz}};

  sync_burst_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_io(dq),
    .sel_n_i(sel_n), .sel_hi_i(sel_hi), .sel2_n_i(sel2_n),
    .strb_cpu_n_i(cpu_n), .strb_ctl_n_i(ctl_n), .next_n_i(nxt_n),
    .lane_wr_n_i(lwr_n), .wr_all_n_i(wall_n), .order_ilv_i(ilv),
    .out_en_n_i(oe_n), .sleep_i(slp)
  );

  task automatic put(input vec_t v);
    cpu_n = v.cpu_n; ctl_n = v.ctl_n; nxt_n = v.nxt_n; sel_n = v.sel_n;
    sel_hi = 1'b1; sel2_n = 1'b0; wall_n = v.wall_n; lwr_n = v.lwr_n;
    ilv = v.ilv; addr = v.addr; tb_wd = v.wd;
    tb_drv = (!v.wall_n || v.lwr_n != 2'b11) && v.cpu_n;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] exp);
    n_chk++;
    if (dq !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, dq, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    addr = '0; sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0; cpu_n = 1'b1; ctl_n = 1'b1;
    nxt_n = 1'b1; lwr_n = 2'b11; wall_n = 1'b1; ilv = 1'b0; oe_n = 1'b0; slp = 1'b0;
    tb_drv = 1'b0; tb_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset R10 bus floats", ZV);

    foreach (VECS[i]) begin
      put(VECS[i]);
      @(negedge clk);
      if (VECS[i].ck != CK_NONE)
        check($sformatf("vec %0d R%0d", i, VECS[i].req), VECS[i].exp);
    end

    // R11: output enable acts without a clock edge
    put('{1,0,1,0,1,2'b11,0,8'h10,'0,CK_NONE,'0,4'd11});
    @(negedge clk);
    put('{1,1,1,0,1,2'b11,0,8'h00,'0,CK_NONE,'0,4'd11});
    @(negedge clk);
    check("R11 read before oe toggle", W0);
    oe_n = 1'b1; #0.5;
    check("R11 oe high floats", ZV);
    oe_n = 1'b0; #0.5;
    check("R11 oe low drives", W0);

    // R12: sleep floats bus and blocks a write
    slp = 1'b1; #0.5;
    check("R12 sleep floats", ZV);
    @(negedge clk);
    put('{1,0,1,0,0,2'b11,0,8'h10,18'h00777,CK_NONE,'0,4'd12});
    @(negedge clk);
    put('{1,1,1,0,1,2'b11,0,8'h00,'0,CK_NONE,'0,4'd12});
    @(negedge clk);
    check("R12 sleep no read", ZV);
    slp = 1'b0;
    put('{1,0,1,0,1,2'b11,0,8'h10,'0,CK_NONE,'0,4'd12});
    @(negedge clk);
    put('{1,0,1,1,1,2'b11,0,8'h00,'0,CK_NONE,'0,4'd12});
    @(negedge clk);
    check("R12 contents kept", W0);
    put('{1,1,1,0,1,2'b11,0,8'h00,'0,CK_NONE,'0,4'd12});
    @(negedge clk);

    // R1: each select input on its own blocks the access
    put('{1,0,1,0,1,2'b11,0,8'h10,'0,CK_NONE,'0,4'd1});
    sel_hi = 1'b0;
    @(negedge clk);
    put('{1,1,1,0,1,2'b11,0,8'h00,'0,CK_NONE,'0,4'd1});
    @(negedge clk);
    check("R1 sel_hi low blocks", ZV);
    put('{1,0,1,0,1,2'b11,0,8'h10,'0,CK_NONE,'0,4'd1});
    sel2_n = 1'b1;
    @(negedge clk);
    put('{1,1,1,0,1,2'b11,0,8'h00,'0,CK_NONE,'0,4'd1});
    @(negedge clk);
    check("R1 sel2_n high blocks", ZV);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule